// File: doc/BRIEF.md
# Pin Test Channel with Gated Stimulus and Phase-Offset Capture

This block connects one pin of a device under test to a stream of 64-bit host words. In drive mode the host loads stimulus words into a small word buffer. A serializer then sends them to the pin one bit per test-clock period, least significant bit first. The pin level is the current vector bit ANDed with the test clock, so the pin pulses only while the test clock is high. In capture mode the channel samples the pin once per period on a probe clock that is offset in phase from the test clock. It packs 64 samples into a word and queues the word for the host to read back.

The block runs on a fast system clock. The test clock and the probe clock are derived from a phase counter of `PHASES` steps: the test clock is high for the first `HIGH_PHASES` steps, and the probe clock is high for the same number of steps starting at `PROBE_PHASE`. With the defaults (4 steps, 1 high), this gives a 25% duty test clock. A threshold flag tells the host when to refill stimulus or drain responses. Because the host can keep pace through this flag, a test can run longer than the buffer holds. Sticky error bits record a starved serializer or a rejected capture word. For seamless streaming, the buffer depth should be at least twice the threshold.

Top module: `pin_test_channel`

## Requirements
- R1: After reset the word buffer is empty, `underrun` and `overrun` are 0, `test_clk`, `probe_clk` and `pin_out` are 0, and in drive mode (`mode`=0) `thresh_flag` is 1 for any threshold.
- R2: While `run` is 1, `test_clk` repeats with a period of `PHASES` system cycles: it is 1 in the first `HIGH_PHASES` cycles after `run` rises, then 0 for the rest of the period. While `run` is 0 it is 0, and the phase returns to step 0.
- R3: In drive mode `pin_out` equals `test_clk` AND the current vector bit, so it is 0 whenever `test_clk` is 0.
- R4: Drive mode sends stimulus words in write order. Word bit 0 is sent first and bit 63 last, and each bit is held for one full test-clock period. The first word is preloaded from the buffer before `run` rises.
- R5: Capture mode takes one sample of `pin_in` per period, in the cycle at phase step `PROBE_PHASE`. Sample k of a group of 64 becomes bit k of the captured word. `probe_clk` is 1 for `HIGH_PHASES` cycles starting at step `PROBE_PHASE`. Values on `pin_in` at other steps have no effect.
- R6: In drive mode `thresh_flag` is 1 exactly when the number of buffered words (not counting the word in the serializer) is at most `threshold`.
- R7: In capture mode `thresh_flag` is 1 exactly when the number of buffered words is at least `threshold`.
- R8: `underrun` becomes 1 when a drive-mode bit period ends while running and no next bit is available (the last bit of a word has been sent and the buffer is empty). It stays 1 until reset.
- R9: `overrun` becomes 1 when a completed capture word finds the buffer full. That word is discarded and the bit stays 1 until reset.
- R10: A host write to a full buffer in drive mode is ignored, and a host read of an empty buffer in capture mode is ignored; neither changes the buffered contents. `host_rd_data` shows the oldest buffered word.
- R11: `pin_oe` is 1 in drive mode and 0 in capture mode, and `pin_out` is 0 in capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = drive stimulus, 1 = capture response |
| run | input | 1 | Test running; enables the test and probe clocks |
| threshold | input | $clog2(DEPTH+1) | Refill/drain level for the flag |
| host_wr_en | input | 1 | Push stimulus word (drive mode) |
| host_wr_data | input | WORD_W | Stimulus word |
| host_rd_en | input | 1 | Pop captured word (capture mode) |
| host_rd_data | output | WORD_W | Oldest buffered word |
| thresh_flag | output | 1 | Refill (drive) or drain (capture) request |
| underrun | output | 1 | Sticky: serializer starved while running |
| overrun | output | 1 | Sticky: capture word lost to a full buffer |
| test_clk | output | 1 | Generated test clock |
| probe_clk | output | 1 | Phase-offset capture clock |
| pin_out | output | 1 | Gated stimulus to the pin |
| pin_oe | output | 1 | Pin output enable |
| pin_in | input | 1 | Pin response level |

## Verification
A wrong shift count or bit order shows on `pin_out` within one test-clock period as a wrong pulse. A lost or repeated word shows only at the next word boundary, 64 periods later. A probe sampling at the wrong step shows only when the host reads the packed word back, one full word after the error. A corrupted buffer level shows on `thresh_flag` at the next push or pop, and through `underrun`/`overrun` at the end of the stream. Because of these delays, the bench compares every pin bit cycle by cycle and every captured word on readback.

// File: rtl/pin_chan_pkg.sv
package pin_chan_pkg;
   typedef enum logic {
      CH_DRIVE   = 1'b0,
      CH_CAPTURE = 1'b1
   } ch_mode_e;
endpackage

// File: rtl/pin_chan_phase.sv
module pin_chan_phase #(
   parameter int PHASES      = 4,
   parameter int HIGH_PHASES = 1,
   parameter int PROBE_PHASE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic test_clk,
   output logic probe_clk,
   output logic bit_end,
   output logic probe_strobe
);
   localparam int PH_W = (PHASES > 2) ? $clog2(PHASES) : 1;
   localparam logic [PH_W-1:0] LAST_L  = PH_W'(PHASES - 1);
   localparam logic [PH_W-1:0] HIGH_L  = PH_W'(HIGH_PHASES);
   localparam logic [PH_W-1:0] PROBE_L = PH_W'(PROBE_PHASE);

   logic [PH_W-1:0] ph;
   logic            in_win;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) ph <= '0;
      else if (ph == LAST_L) ph <= '0;
      else ph <= ph + 1'b1;
   end

   generate
      if (PROBE_PHASE + HIGH_PHASES <= PHASES) begin : g_win_plain
         localparam logic [PH_W:0] END_L = (PH_W+1)'(PROBE_PHASE + HIGH_PHASES);
         assign in_win = (ph >= PROBE_L) && ({1'b0, ph} < END_L);
      end else begin : g_win_wrap
         localparam logic [PH_W-1:0] WEND_L = PH_W'(PROBE_PHASE + HIGH_PHASES - PHASES);
         assign in_win = (ph >= PROBE_L) || (ph < WEND_L);
      end
   endgenerate

   assign test_clk     = run && (ph < HIGH_L);
   assign probe_clk    = run && in_win;
   assign bit_end      = run && (ph == LAST_L);
   assign probe_strobe = run && (ph == PROBE_L);

   // R2
   tclk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end ##1 run |-> test_clk);
endmodule

// File: rtl/pin_chan_fifo.sv
module pin_chan_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int AW    = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         if (push_ok && !pop_ok)      level <= level + 1'b1;
         else if (pop_ok && !push_ok) level <= level - 1'b1;
      end
   end

   // R10
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> ($stable(level) && $stable(wr_ptr)));
   // R10
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/pin_chan_ser.sv
module pin_chan_ser #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         bit_end,
   input  logic         fifo_empty,
   input  logic [W-1:0] fifo_dout,
   output logic         fifo_pop,
   output logic         cur_bit,
   output logic         underrun
);
   localparam int BW = $clog2(W);
   localparam logic [BW-1:0] LAST_L = BW'(W - 1);

   logic [W-1:0]  sreg;
   logic [BW-1:0] bcnt;
   logic          loaded;
   logic          need;

   assign need     = en && (!loaded || (bit_end && bcnt == LAST_L));
   assign fifo_pop = need && !fifo_empty;
   assign cur_bit  = loaded && sreg[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg     <= '0;
         bcnt     <= '0;
         loaded   <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (en && bit_end && need && fifo_empty) underrun <= 1'b1;
         if (need && !fifo_empty) begin
            sreg   <= fifo_dout;
            bcnt   <= '0;
            loaded <= 1'b1;
         end else if (en && bit_end && loaded) begin
            sreg <= sreg >> 1;
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST_L) loaded <= 1'b0;
         end
      end
   end

   // R4
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && loaded && !bit_end) |=> $stable(sreg));
   // R8
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
endmodule

// File: rtl/pin_chan_des.sv
module pin_chan_des #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         probe_strobe,
   input  logic         pin_in,
   input  logic         fifo_full,
   output logic [W-1:0] word,
   output logic         push,
   output logic         overrun
);
   localparam int BW = $clog2(W);
   localparam logic [BW-1:0] LAST_L = BW'(W - 1);

   logic [W-1:0]  csreg;
   logic [BW-1:0] ccnt;
   logic          take;

   assign take = en && probe_strobe;
   assign word = {pin_in, csreg[W-1:1]};
   assign push = take && (ccnt == LAST_L);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csreg   <= '0;
         ccnt    <= '0;
         overrun <= 1'b0;
      end else begin
         if (take) begin
            csreg <= word;
            ccnt  <= (ccnt == LAST_L) ? '0 : ccnt + 1'b1;
         end
         if (push && fifo_full) overrun <= 1'b1;
      end
   end

   // R5
   sample_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !probe_strobe |=> $stable(ccnt));
   // R9
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

// File: rtl/pin_test_channel.sv
module pin_test_channel
   import pin_chan_pkg::*;
#(
   parameter int WORD_W      = 64,
   parameter int DEPTH       = 8,
   parameter int PHASES      = 4,
   parameter int HIGH_PHASES = 1,
   parameter int PROBE_PHASE = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode,
   input  logic                       run,
   input  logic [$clog2(DEPTH+1)-1:0] threshold,
   input  logic                       host_wr_en,
   input  logic [WORD_W-1:0]          host_wr_data,
   input  logic                       host_rd_en,
   output logic [WORD_W-1:0]          host_rd_data,
   output logic                       thresh_flag,
   output logic                       underrun,
   output logic                       overrun,
   output logic                       test_clk,
   output logic                       probe_clk,
   output logic                       pin_out,
   output logic                       pin_oe,
   input  logic                       pin_in
);
   localparam int LVL_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a power of two, at least 2");
      end
      if (PHASES < 2 || HIGH_PHASES < 1 || HIGH_PHASES >= PHASES) begin : g_bad_duty
         $error("HIGH_PHASES must lie in 1..PHASES-1");
      end
      if (PROBE_PHASE < 0 || PROBE_PHASE >= PHASES) begin : g_bad_probe
         $error("PROBE_PHASE must lie in 0..PHASES-1");
      end
   endgenerate

   ch_mode_e          md;
   logic              drive_en, cap_en;
   logic              bit_end, probe_strobe;
   logic              f_push, f_pop, f_full, f_empty;
   logic [WORD_W-1:0] f_din, f_dout;
   logic [LVL_W-1:0]  f_level;
   logic              ser_pop, ser_bit;
   logic              des_push;
   logic [WORD_W-1:0] des_word;

   assign md       = ch_mode_e'(mode);
   assign drive_en = (md == CH_DRIVE);
   assign cap_en   = (md == CH_CAPTURE);

   pin_chan_phase #(
      .PHASES(PHASES), .HIGH_PHASES(HIGH_PHASES), .PROBE_PHASE(PROBE_PHASE)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run),
      .test_clk(test_clk), .probe_clk(probe_clk),
      .bit_end(bit_end), .probe_strobe(probe_strobe)
   );

   assign f_push = drive_en ? host_wr_en   : des_push;
   assign f_din  = drive_en ? host_wr_data : des_word;
   assign f_pop  = drive_en ? ser_pop      : host_rd_en;

   pin_chan_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(f_push), .din(f_din), .pop(f_pop), .dout(f_dout),
      .full(f_full), .empty(f_empty), .level(f_level)
   );

   pin_chan_ser #(.W(WORD_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .en(drive_en), .bit_end(bit_end),
      .fifo_empty(f_empty), .fifo_dout(f_dout), .fifo_pop(ser_pop),
      .cur_bit(ser_bit), .underrun(underrun)
   );

   pin_chan_des #(.W(WORD_W)) u_des (
      .clk(clk), .rst_n(rst_n), .en(cap_en), .probe_strobe(probe_strobe),
      .pin_in(pin_in), .fifo_full(f_full), .word(des_word),
      .push(des_push), .overrun(overrun)
   );

   assign host_rd_data = f_dout;
   assign thresh_flag  = drive_en ? (f_level <= threshold) : (f_level >= threshold);
   assign pin_out      = drive_en && test_clk && ser_bit;
   assign pin_oe       = drive_en;

   // R6
   refill_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && f_empty) |-> thresh_flag);
   // R7
   drain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && f_full && threshold <= LVL_W'(DEPTH)) |-> thresh_flag);
endmodule

// File: tb/pin_test_channel_bench.sv
module pin_test_channel_bench;
   localparam int W   = 64;
   localparam int DEP = 8;
   localparam int PH  = 4;
   localparam int HI  = 1;
   localparam int PR  = 2;
   localparam int LW  = $clog2(DEP+1);
   localparam int NWD = 9;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, mode, run, host_wr_en, host_rd_en, pin_in;
   logic [LW-1:0] threshold;
   logic [W-1:0]  host_wr_data, host_rd_data;
   logic          thresh_flag, underrun, overrun, test_clk, probe_clk, pin_out, pin_oe;

   pin_test_channel u_pin_test_channel (
      .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .threshold(threshold),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
      .thresh_flag(thresh_flag), .underrun(underrun), .overrun(overrun),
      .test_clk(test_clk), .probe_clk(probe_clk), .pin_out(pin_out),
      .pin_oe(pin_oe), .pin_in(pin_in)
   );

   int errs = 0;
   int checks = 0;
   logic [W-1:0] dwords [NWD];
   logic [W-1:0] cwords [NWD];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit exp_tclk(int j);
      return (j % PH) < HI;
   endfunction

   function automatic bit exp_pclk(int j);
      int p = j % PH;
      return (p >= PR) && (p < PR + HI);
   endfunction

   initial begin
      #2_000_000;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] cur;
      logic [W-1:0] pat;
      int bits, done;
      void'($urandom(32'h5EED_0C4A));
      rst_n = 0; mode = 0; run = 0; threshold = LW'(3);
      host_wr_en = 0; host_rd_en = 0; host_wr_data = '0; pin_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1 reset state
      chk(underrun == 0 && overrun == 0, "R1 sticky bits", {underrun, overrun}, 0);
      chk(test_clk == 0 && probe_clk == 0 && pin_out == 0, "R1 clocks idle",
          {test_clk, probe_clk, pin_out}, 0);
      chk(thresh_flag == 1, "R1 drive flag", thresh_flag, 1);
      chk(pin_oe == 1, "R11 drive oe", pin_oe, 1);

      dwords[0] = '0;
      dwords[1] = '1;
      dwords[2] = 64'hAAAA_AAAA_AAAA_AAAA;
      dwords[3] = 64'h8000_0000_0000_0001;
      for (int k = 4; k < NWD; k++) dwords[k] = {$urandom, $urandom};

      for (int k = 0; k < NWD; k++) begin
         @(negedge clk);
         host_wr_en = 1; host_wr_data = dwords[k];
      end
      @(negedge clk);
      host_wr_data = 64'hDEAD_BEEF_0BAD_F00D;   // R10 buffer full: must be dropped
      @(negedge clk);
      host_wr_en = 0;
      repeat (3) @(negedge clk);

      run = 1;
      for (int j = 0; j < NWD*W*PH + 8; j++) begin
         int b, w, lvl;
         bit eb;
         if (j > 0) @(negedge clk);
         #1;
         b = j / PH;
         w = b / W;
         lvl = (w < DEP) ? DEP - w : 0;
         eb = (b < NWD*W) ? dwords[w][b % W] : 1'b0;
         chk(test_clk == exp_tclk(j), "R2 test_clk", test_clk, exp_tclk(j));
         chk(probe_clk == exp_pclk(j), "R5 probe_clk", probe_clk, exp_pclk(j));
         chk(pin_out == (eb & exp_tclk(j)), "R3 R4 pin_out", pin_out, eb & exp_tclk(j));
         chk(thresh_flag == (lvl <= 3), "R6 refill flag", thresh_flag, lvl <= 3);
         chk(underrun == (b >= NWD*W), "R8 underrun", underrun, b >= NWD*W);
      end
      @(negedge clk);
      run = 0;
      #1;
      chk(test_clk == 0 && pin_out == 0, "R2 stopped", {test_clk, pin_out}, 0);
      chk(underrun == 1, "R8 sticky after stop", underrun, 1);

      @(negedge clk);
      rst_n = 0; mode = 1; threshold = LW'(2);
      repeat (2) @(negedge clk);
      rst_n = 1;
      #1;
      chk(pin_oe == 0, "R11 capture oe", pin_oe, 0);
      chk(thresh_flag == 0, "R7 empty flag", thresh_flag, 0);
      chk(underrun == 0 && overrun == 0, "R1 sticky cleared", {underrun, overrun}, 0);

      bits = 0; done = 0; cur = '0;
      @(negedge clk);
      run = 1;
      for (int j = 0; j < NWD*W*PH; j++) begin
         int lvl;
         if (j > 0) @(negedge clk);
         pin_in = 1'($urandom);
         #1;
         lvl = (done > DEP) ? DEP : done;
         chk(probe_clk == exp_pclk(j), "R5 probe_clk", probe_clk, exp_pclk(j));
         chk(test_clk == exp_tclk(j), "R2 test_clk", test_clk, exp_tclk(j));
         chk(pin_out == 0, "R11 no drive in capture", pin_out, 0);
         chk(thresh_flag == (lvl >= 2), "R7 drain flag", thresh_flag, lvl >= 2);
         chk(overrun == (done > DEP), "R9 overrun", overrun, done > DEP);
         if (j % PH == PR) begin
            cur[bits % W] = pin_in;
            bits++;
            if (bits % W == 0) begin
               cwords[done] = cur;
               done++;
            end
         end
      end
      @(negedge clk);
      run = 0;

      for (int k = 0; k < DEP; k++) begin
         @(negedge clk);
         host_rd_en = 0;
         #1;
         chk(host_rd_data == cwords[k], "R5 R9 captured word", host_rd_data, cwords[k]);
         host_rd_en = 1;
      end
      @(negedge clk);
      host_rd_en = 1;   // R10 read of empty buffer
      @(negedge clk);
      host_rd_en = 0;
      #1;
      chk(thresh_flag == 0, "R7 drained", thresh_flag, 0);
      chk(overrun == 1, "R9 sticky", overrun, 1);

      pat = 64'h0123_4567_89AB_CDEF;
      @(negedge clk);
      run = 1;
      for (int j = 0; j < W*PH; j++) begin
         if (j > 0) @(negedge clk);
         pin_in = (j % PH == PR) ? pat[j / PH] : ~pat[j / PH];
      end
      @(negedge clk);
      run = 0;
      #1;
      chk(host_rd_data == pat, "R10 R5 word after empty read", host_rd_data, pat);
      chk(thresh_flag == 0, "R7 one word below threshold", thresh_flag, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule